// File: doc/BRIEF.md
# I2C Target Port

A byte-wide I2C target (slave) for a processor bus. Received bits are shifted into a shift register and copied into a holding buffer once the byte completes, so the receiver is double-buffered. After each accepted byte an interrupt flag is set. The port can then hold SCL low until firmware has dealt with the byte and set the clock-release bit. A status register tells firmware four things: whether the last byte was an address or data, the direction of the transfer, which bus condition was seen last (START or STOP), and whether the buffer holds an unread byte. The first control register holds the sticky error bits for receive overflow and write collision.

The host sees five registers through `reg_sel`:

| `reg_sel` | Register |
|---|---|
| 0 | Status |
| 1 | Control 1 |
| 2 | Control 2 |
| 3 | Data buffer |
| 4 | Own address |

Writes are synchronous and take effect on the clock edge where `wr_en` is high. `rd_data` is combinational. A read of the data buffer takes effect on the clock edge where `rd_en` is high.

Bus lines are open drain. `scl_hold` and `sda_pull` are asserted when the port pulls the line low. The bus side samples `scl_i` and `sda_i` through two-stage synchronizers, and the system clock must run well above the SCL rate.

Top module: `i2c_target_port`

## Requirements
- R1: After reset, every register reads 0x00, both line drives are released and `irq` is low.
- R2: The port must be enabled (control 1 bit 5 = 1) and in target mode (control 1 bits 3:0 = 0110). In that state it compares bits 7:1 of the first byte after a START with own-address bits 7:1. On a match it pulls SDA low through the 9th clock and the flag is set. The address byte is copied to the buffer, BF (status bit 0) is set, D/A (status bit 5) reads 0, and R/W (status bit 2) takes address bit 0, where 1 means read. On a mismatch nothing is acknowledged and no status changes.
- R3: In a write transfer, each following byte is acknowledged and copied to the buffer. BF and the flag are set and D/A reads 1.
- R4: A host read of the data buffer (`reg_sel`=3 with `rd_en`) clears BF.
- R5: If a byte completes while BF is set, the overflow bit (control 1 bit 6) is set and the buffer keeps its earlier byte. The host clears the overflow bit by writing 0 to it.
- R6: Clock stretching is enabled by control 2 bit 0. In a write transfer with stretching enabled, the port clears CKP (control 1 bit 4) after the acknowledge of each byte and holds SCL low until the host writes CKP=1. With stretching disabled it does not hold SCL. An address match for a read always stretches.
- R7: In a read transfer, a byte written to the data buffer sets BF. After release, that byte goes out MSB first and BF clears when shifting starts. A controller ACK sets the flag and makes D/A read 1, and with stretching enabled it stretches again. A NACK ends the transfer with SDA released.
- R8: A host write to the data buffer while a byte is shifting out sets the write-collision bit (control 1 bit 7) and leaves the byte being sent unchanged.
- R9: S (status bit 3) is set by a START and P (status bit 4) by a STOP. Each clears the other.
- R10: When disabled or in any other mode, the port drives neither line and ignores bus traffic. Status does not change and nothing is acknowledged.
- R11: The flag is control 2 bit 2. It is cleared only by a host write with that bit 0, and writing 1 to it has no effect. `irq` is high when both the flag and the enable (control 2 bit 1) are 1.
- R12: In the status register, host writes change only bits 7:6. Bits 5:0 are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_hold | output | 1 | Pull SCL low (clock stretch) |
| sda_pull | output | 1 | Pull SDA low |
| reg_sel | input | 3 | Register select |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the write collision, because it needs a host write to land while a byte is actually shifting out. The bench gets there by driving the controller side bit by bit. After three data bits of a read it pauses with SCL low, writes the buffer, and then finishes clocking the byte to show that the original value still arrives. Overflow is reached in a similar way: stretching is disabled and the address byte is left unread in the buffer, so the next data byte finds BF already set.

// File: rtl/i2c_target_port.sv
`timescale 1ns/1ps
module i2c_target_port #(
  parameter logic [3:0] TGT_MODE = 4'b0110,
  parameter int         SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_hold,
  output logic             sda_pull,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             irq
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACKW, S_ACKD, S_HOLD, S_TX, S_ACKIN} st_t;

  st_t        state;
  logic [2:0] scl_q, sda_q;
  logic [7:0] shreg, dbuf, own_addr;
  logic [3:0] cnt;
  logic       is_addr, got_nack;
  logic [1:0] st_hi;
  logic       st_da, st_stop, st_start, st_rd, st_full;
  logic       c_wcol, c_ovf, c_en, c_rel;
  logic [3:0] c_mode;
  logic       stretch_en, irq_en, irq_flag;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_now    = scl_q[1];
  wire scl_old    = scl_q[2];
  wire sda_now    = sda_q[1];
  wire sda_old    = sda_q[2];
  wire scl_rise   = scl_now & ~scl_old;
  wire scl_fall   = ~scl_now & scl_old;
  wire start_cond = scl_now & scl_old & sda_old & ~sda_now;
  wire stop_cond  = scl_now & scl_old & ~sda_old & sda_now;
  wire active     = c_en && (c_mode == TGT_MODE);
  wire [7:0] rx_next = {shreg[6:0], sda_now};
  wire addr_hit   = rx_next[7:1] == own_addr[7:1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      shreg <= '0; dbuf <= '0; own_addr <= '0; cnt <= '0;
      is_addr <= 1'b0; got_nack <= 1'b0;
      st_hi <= '0; st_da <= 1'b0; st_stop <= 1'b0; st_start <= 1'b0;
      st_rd <= 1'b0; st_full <= 1'b0;
      c_wcol <= 1'b0; c_ovf <= 1'b0; c_en <= 1'b0; c_rel <= 1'b0; c_mode <= '0;
      stretch_en <= 1'b0; irq_en <= 1'b0; irq_flag <= 1'b0;
    end else begin
      if (wr_en)
        case (reg_sel)
          3'd0: st_hi <= wr_data[7:6];
          3'd1: {c_wcol, c_ovf, c_en, c_rel, c_mode} <= wr_data;
          3'd2: begin
            stretch_en <= wr_data[0];
            irq_en     <= wr_data[1];
            if (!wr_data[2]) irq_flag <= 1'b0;
          end
          3'd3:
            if (state == S_TX) c_wcol <= 1'b1;
            else begin
              dbuf <= wr_data;
              if (st_rd) st_full <= 1'b1;
            end
          3'd4: own_addr <= wr_data;
          default: ;
        endcase
      if (rd_en && reg_sel == 3'd3) st_full <= 1'b0;

      if (!active) state <= S_IDLE;
      else if (start_cond) begin
        state <= S_RX; cnt <= '0; is_addr <= 1'b1;
        st_start <= 1'b1; st_stop <= 1'b0;
      end else if (stop_cond) begin
        state <= S_IDLE; st_stop <= 1'b1; st_start <= 1'b0;
      end else
        case (state)
          S_RX:
            if (scl_rise) begin
              shreg <= rx_next;
              cnt   <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                if (is_addr && !addr_hit) state <= S_IDLE;
                else begin
                  state <= S_ACKW;
                  st_da <= !is_addr;
                  if (is_addr) st_rd <= rx_next[0];
                  if (st_full) c_ovf <= 1'b1;
                  else dbuf <= rx_next;
                  st_full  <= 1'b1;
                  irq_flag <= 1'b1;
                end
              end
            end
          S_ACKW: if (scl_fall) state <= S_ACKD;
          S_ACKD:
            if (scl_fall) begin
              if ((is_addr && st_rd) || stretch_en) begin
                c_rel <= 1'b0;
                state <= S_HOLD;
              end else begin
                cnt <= '0; is_addr <= 1'b0; state <= S_RX;
              end
            end
          S_HOLD:
            if (c_rel) begin
              cnt <= '0; is_addr <= 1'b0;
              if (st_rd) begin
                state <= S_TX; shreg <= dbuf; st_full <= 1'b0;
              end else state <= S_RX;
            end
          S_TX: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            if (scl_fall) begin
              if (cnt == 4'd8) state <= S_ACKIN;
              else shreg <= {shreg[6:0], 1'b0};
            end
          end
          S_ACKIN: begin
            if (scl_rise) got_nack <= sda_now;
            if (scl_fall) begin
              if (got_nack) state <= S_IDLE;
              else begin
                st_da <= 1'b1; irq_flag <= 1'b1;
                if (stretch_en) begin
                  c_rel <= 1'b0; state <= S_HOLD;
                end else begin
                  state <= S_TX; shreg <= dbuf; st_full <= 1'b0; cnt <= '0;
                end
              end
            end
          end
          default: ;
        endcase
    end

  assign scl_hold = (state == S_HOLD);
  assign sda_pull = (state == S_ACKD) || (state == S_TX && !shreg[7]);
  assign irq      = irq_flag & irq_en;

  always_comb
    case (reg_sel)
      3'd0:    rd_data = {st_hi, st_da, st_stop, st_start, st_rd, 1'b0, st_full};
      3'd1:    rd_data = {c_wcol, c_ovf, c_en, c_rel, c_mode};
      3'd2:    rd_data = {5'b0, irq_flag, irq_en, stretch_en};
      3'd3:    rd_data = dbuf;
      3'd4:    rd_data = own_addr;
      default: rd_data = 8'h00;
    endcase

  // R10
  idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !scl_hold && !sda_pull);
  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold && c_rel |=> !scl_hold);
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_ovf) |-> $past(st_full) || $past(wr_en && reg_sel == 3'd1 && wr_data[6]));
  // R8
  collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_wcol) |-> $past(state == S_TX) || $past(wr_en && reg_sel == 3'd1 && wr_data[7]));
  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flag) |-> $past(wr_en && reg_sel == 3'd2 && !wr_data[2]));
  // R9
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_start && st_stop));
endmodule

// File: tb/sim_i2c_target_port.sv
`timescale 1ns/1ps
module sim_i2c_target_port;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_sel = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       scl_hold, sda_pull, irq;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       scl_w, sda_w;
  int         checks = 0, fails = 0;

  assign scl_w = m_scl & ~scl_hold;
  assign sda_w = m_sda & ~sda_pull;

  always #4 clk = ~clk;

  i2c_target_port u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .scl_hold(scl_hold), .sda_pull(sda_pull), .reg_sel(reg_sel),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic half();
    repeat (12) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1; half();
    m_sda = 1'b0; half();
    m_scl = 1'b0; half();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; half();
    m_scl = 1'b1; half();
    m_sda = 1'b1; half();
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda = b; half();
    m_scl = 1'b1;
    for (int k = 0; k < 5000 && !scl_w; k++) @(negedge clk);
    half();
    r = sda_w;
    m_scl = 1'b0; half();
  endtask

  task automatic m_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(v[i], r);
    m_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic m_rdbyte(output logic [7:0] v);
    logic r;
    v = '0;
    for (int i = 0; i < 8; i++) begin m_bit(1'b1, r); v = {v[6:0], r}; end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int s = 0; s < 5; s++) begin host_rd(3'(s), d); chk("R1 reg", d, 8'h00); end
    chk("R1 lines", {6'b0, scl_hold, sda_pull}, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_write_stretch();
    logic [7:0] d; logic a;
    host_wr(3'd4, 8'hAA); host_wr(3'd1, 8'h36); host_wr(3'd2, 8'h03);
    m_start();
    host_rd(3'd0, d); chk("R9 start", d & 8'h18, 8'h08);
    m_byte(8'hAA, a); chk("R2 ack", {7'b0, a}, 8'h01);
    chk("R6 hold", {7'b0, scl_hold}, 8'h01);
    host_rd(3'd0, d); chk("R2 status", d, 8'h09);
    host_rd(3'd1, d); chk("R6 ckp low", d, 8'h26);
    chk("R11 irq", {7'b0, irq}, 8'h01);
    host_rd(3'd3, d); chk("R2 buffer", d, 8'hAA);
    host_rd(3'd0, d); chk("R4 bf clear", d & 8'h01, 8'h00);
    host_wr(3'd2, 8'h07);
    chk("R11 write 1 keeps", {7'b0, irq}, 8'h01);
    host_wr(3'd2, 8'h03);
    chk("R11 cleared", {7'b0, irq}, 8'h00);
    host_wr(3'd1, 8'h36);
    repeat (3) @(negedge clk);
    chk("R6 released", {7'b0, scl_hold}, 8'h00);
    m_byte(8'h5C, a); chk("R3 ack", {7'b0, a}, 8'h01);
    chk("R6 hold data", {7'b0, scl_hold}, 8'h01);
    host_rd(3'd0, d); chk("R3 status", d, 8'h29);
    host_rd(3'd3, d); chk("R3 buffer", d, 8'h5C);
    host_wr(3'd2, 8'h03); host_wr(3'd1, 8'h36);
    m_stop();
    host_rd(3'd0, d); chk("R9 stop", d, 8'h30);
  endtask

  task automatic t_mismatch();
    logic [7:0] d; logic a;
    m_start(); m_byte(8'hB4, a); m_stop();
    chk("R2 nack", {7'b0, a}, 8'h00);
    host_rd(3'd2, d); chk("R2 no flag", d & 8'h04, 8'h00);
  endtask

  task automatic t_overflow();
    logic [7:0] d; logic a;
    host_wr(3'd2, 8'h02);
    m_start(); m_byte(8'hAA, a);
    chk("R6 no stretch", {7'b0, scl_hold}, 8'h00);
    m_byte(8'h3C, a);
    host_rd(3'd1, d); chk("R5 ovf set", d, 8'h76);
    host_rd(3'd3, d); chk("R5 buffer kept", d, 8'hAA);
    m_stop();
    host_wr(3'd1, 8'h36);
    host_rd(3'd1, d); chk("R5 ovf cleared", d, 8'h36);
    host_wr(3'd2, 8'h02);
  endtask

  task automatic t_read();
    logic [7:0] d, v; logic a, r;
    host_wr(3'd2, 8'h03);
    m_start(); m_byte(8'hAB, a);
    chk("R2 read ack", {7'b0, a}, 8'h01);
    chk("R6 read hold", {7'b0, scl_hold}, 8'h01);
    host_rd(3'd0, d); chk("R2 read status", d, 8'h0D);
    host_rd(3'd3, d);
    host_wr(3'd3, 8'hA5);
    host_rd(3'd0, d); chk("R7 bf on load", d & 8'h01, 8'h01);
    host_wr(3'd1, 8'h36);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      m_bit(1'b1, r); v = {v[6:0], r};
      if (i == 2) begin
        host_rd(3'd0, d); chk("R7 bf cleared on shift", d & 8'h01, 8'h00);
        host_wr(3'd3, 8'h11);
        host_rd(3'd1, d); chk("R8 wcol", d, 8'hB6);
      end
    end
    chk("R8 R7 byte out", v, 8'hA5);
    m_bit(1'b0, r);
    chk("R7 hold after ack", {7'b0, scl_hold}, 8'h01);
    host_rd(3'd0, d); chk("R7 status", d, 8'h2C);
    host_wr(3'd3, 8'h3E); host_wr(3'd1, 8'h36);
    m_rdbyte(v);
    chk("R7 second byte", v, 8'h3E);
    m_bit(1'b1, r);
    chk("R7 sda released", {7'b0, sda_pull}, 8'h00);
    m_stop();
  endtask

  task automatic t_status_ro();
    logic [7:0] pre, d;
    host_rd(3'd0, pre);
    host_wr(3'd0, 8'hFF);
    host_rd(3'd0, d); chk("R12 status write", d, {2'b11, pre[5:0]});
    host_wr(3'd0, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] pre, d; logic a;
    host_wr(3'd2, 8'h03);
    host_wr(3'd1, 8'h16);
    host_rd(3'd0, pre);
    m_start(); m_byte(8'hAA, a); m_stop();
    chk("R10 disabled nack", {7'b0, a}, 8'h00);
    host_rd(3'd0, d); chk("R10 status kept", d, pre);
    host_wr(3'd1, 8'h37);
    m_start(); m_byte(8'hAA, a); m_stop();
    chk("R10 mode nack", {7'b0, a}, 8'h00);
    chk("R10 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_irq_mask();
    logic [7:0] d; logic a;
    host_wr(3'd1, 8'h36); host_wr(3'd2, 8'h01);
    m_start(); m_byte(8'hAA, a);
    host_rd(3'd2, d); chk("R11 flag set", d, 8'h05);
    chk("R11 masked irq", {7'b0, irq}, 8'h00);
    host_rd(3'd3, d);
    host_wr(3'd1, 8'h36);
    m_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_stretch();
    t_mismatch();
    t_overflow();
    t_read();
    t_status_ro();
    t_disabled();
    t_irq_mask();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule